// File: doc/BRIEF.md
# Double-Buffered Video Timing Register Bank

This block is the software-visible register file placed between a host port and a video timing datapath. It holds a control word, a software reset, a sticky status word, an interrupt control word, ten user timing values, a two-bit colour-mosaic phase, and ten read-only measured timing values. The host port has no handshake. A write is taken on any cycle where `host_wr` is high and the address is word aligned. Reads are combinational from `host_addr`.

After reset the timing values follow the measurement inputs on every cycle, so the datapath runs with whatever the input stream shows. The first host write to any timing slot freezes the whole set. From then on the written slot holds the host value, and every other slot keeps the measured value it had at that moment. The frozen values stay in shadow registers. They are copied into the working registers that drive the datapath only at the end of vertical blanking, and only while the host has raised its done semaphore. Status events are held in sticky flags. Each rising flag can be enabled to raise a level interrupt that stays high until the host clears it.

Word map used throughout: 0x00 control, 0x04 software reset, 0x08 status, 0x0C interrupt control, 0x10 + 4*i timing slot i (i = 0..9), 0x38 mosaic phase, 0x3C + 4*i measured slot i. Slot order: 0 first active column, 1 first inactive column on the right, 2 first active row, 3 first inactive row below, 4 total rows, 5 total columns, 6 blank rows, 7 first non-blank column, 8 first blank column on the right, 9 blanking polarity (bit 1 vertical, bit 0 horizontal).

Top module: `tmr_regbank`

## Requirements
- R1: After reset, control reads 0x1, software reset reads 0, interrupt control reads 0, status reads 0 while `lock_in` is low, and `irq` is low.
- R2: Control (bits 2:0), software reset (bit 0) and interrupt control (bits 0, 1, 16:8) read back exactly what was written. Other bits read 0.
- R3: Until the first host timing write, each timing slot reads, and drives on `work_flat`, its measured input. The value is updated one clock after the input changes.
- R4: A host write to any timing slot (0x10..0x34) freezes all slots. Later measurement changes no longer reach the shadow values or `work_flat`, and `work_flat` is unchanged until a commit.
- R5: A commit copies all shadow values to `work_flat` on the clock where `vblank_in` is seen falling (high to low) while control bit 0 (enable) and bit 1 (semaphore) are both 1. A falling edge with the semaphore at 0 changes nothing.
- R6: Measured slot i reads at 0x3C + 4*i, and host writes to those words are ignored.
- R7: While software reset bit 0 is 1, `work_flat`, `bayer_out` and `core_en` are 0. After the bit clears, the slots track measured values again.
- R8: Status bit 7 equals `lock_in`. Bits 16:8 are sticky and set by `evt_in[8:0]`. While control bit 2 is 1 they are held at 0.
- R9: `irq` is high when interrupt control bit 0 is set and a status bit j (8..16) with interrupt enable bit j set has risen. It stays high until interrupt control bit 1 is written 1. Rising bits whose enable is 0 do not raise it.
- R10: Column slots (0, 1, 5, 7, 8) keep the low COLS_W bits of the written value, row slots (2, 3, 4, 6) keep the low ROWS_W bits, and slot 9 keeps 2 bits (COLS_W=10, ROWS_W=9 at defaults).
- R11: The mosaic phase (0x38, bits 1:0) resets to 0, reads back its shadow value, and reaches `bayer_out` only on a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 8 | Byte address of the word |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for host_addr |
| vblank_in | input | 1 | Vertical blanking, high = blanked |
| lock_in | input | 1 | Timing lock level |
| evt_in | input | 9 | Event pulses for status bits 16:8 |
| meas_flat | input | 100 | Ten measured values, 10 bits each, slot 0 lowest |
| work_flat | output | 100 | Ten working values, same packing |
| bayer_out | output | 2 | Working mosaic phase |
| core_en | output | 1 | Datapath enable |
| irq | output | 1 | Interrupt request |

## Verification
The timing slots are exercised with three patterns: changing measurements before any host write, changing measurements after a write, and vblank falling edges with and without the semaphore. Together these separate live tracking, freezing, and gated commit. Oversized row and column writes show per-slot truncation. A software reset in the middle of the run shows both the zeroed outputs and the return to tracking. Events are sent on an enabled bit and on a disabled bit, followed by a status clear and then a source clear, to separate sticky status from sticky interrupt.

// File: rtl/tmr_regbank_pkg.sv
package tmr_regbank_pkg;
  localparam int NSLOT    = 10;
  localparam int NEV      = 9;
  localparam int W_CTRL   = 0;
  localparam int W_SWRST  = 1;
  localparam int W_STAT   = 2;
  localparam int W_INTC   = 3;
  localparam int W_SLOT0  = 4;
  localparam int W_PHASE  = 14;
  localparam int W_MEAS0  = 15;

  // kept width of a timing slot: rows, columns or the 2-bit polarity
  function automatic int slot_w(int idx, int cw, int rw);
    case (idx)
      2, 3, 4, 6: return rw;
      9:          return 2;
      default:    return cw;
    endcase
  endfunction
endpackage

// File: rtl/tmr_shadow_slot.sv
module tmr_shadow_slot #(
  parameter int SW   = 10,
  parameter int KEEP = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          swrst,
  input  logic          track,
  input  logic          commit,
  input  logic          wr_hit,
  input  logic [SW-1:0] wval,
  input  logic [SW-1:0] meas,
  output logic [SW-1:0] meas_view,
  output logic [SW-1:0] shadow,
  output logic [SW-1:0] work
);
  localparam logic [SW-1:0] MASK = {SW{1'b1}} >> (SW - KEEP);

  assign meas_view = meas & MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadow <= '0;
    else if (swrst)  shadow <= meas_view;
    else if (wr_hit) shadow <= wval & MASK;
    else if (track)  shadow <= meas_view;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      work <= '0;
    else if (swrst)  work <= meas_view;
    else if (track)  work <= meas_view;
    else if (commit) work <= shadow;
  end

  p_track_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (track && !swrst) |=> (work == $past(meas_view)));
  p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!track && !commit && !swrst) |=> $stable(work));
endmodule

// File: rtl/tmr_irq_agg.sv
module tmr_irq_agg #(
  parameter int NEV = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt,
  input  logic           clr_stat,
  input  logic           glob_en,
  input  logic [NEV-1:0] src_en,
  input  logic           clr_src,
  output logic [NEV-1:0] stat,
  output logic           irq
);
  logic [NEV-1:0] stat_q1;
  logic [NEV-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat    <= '0;
      stat_q1 <= '0;
      pend    <= '0;
    end else begin
      stat    <= clr_stat ? '0 : (stat | evt);
      stat_q1 <= stat;
      pend    <= clr_src ? '0 : (pend | (stat & ~stat_q1 & src_en));
    end
  end

  assign irq = glob_en & (|pend);

  p_status_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stat |=> (stat == '0));
  p_pend_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pend) && !clr_src) |=> (|pend));
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
  import tmr_regbank_pkg::*;
#(
  parameter int MAX_COLS = 1024,
  parameter int MAX_ROWS = 512,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   host_addr,
  input  logic                                host_wr,
  input  logic [DATA_W-1:0]                   host_wdata,
  output logic [DATA_W-1:0]                   host_rdata,
  input  logic                                vblank_in,
  input  logic                                lock_in,
  input  logic [NEV-1:0]                      evt_in,
  input  logic [NSLOT*((($clog2(MAX_COLS)) > ($clog2(MAX_ROWS))) ? $clog2(MAX_COLS) : $clog2(MAX_ROWS))-1:0] meas_flat,
  output logic [NSLOT*((($clog2(MAX_COLS)) > ($clog2(MAX_ROWS))) ? $clog2(MAX_COLS) : $clog2(MAX_ROWS))-1:0] work_flat,
  output logic [1:0]                          bayer_out,
  output logic                                core_en,
  output logic                                irq
);
  localparam int COLS_W = $clog2(MAX_COLS);
  localparam int ROWS_W = $clog2(MAX_ROWS);
  localparam int SLOT_W = (COLS_W > ROWS_W) ? COLS_W : ROWS_W;
  localparam int WRD_W  = ADDR_W - 2;

  logic [WRD_W-1:0] word;
  logic             aligned, wr_ok;
  logic [2:0]       ctrl;
  logic             swrst;
  logic [1:0]       intc_lo;
  logic [NEV-1:0]   intc_en;
  logic             frozen, vb_q, commit;
  logic [1:0]       ph_shadow, ph_work;
  logic [NEV-1:0]   stat;
  logic [NSLOT-1:0] slot_wr;
  logic [SLOT_W-1:0] sh_a [NSLOT];
  logic [SLOT_W-1:0] wk_a [NSLOT];
  logic [SLOT_W-1:0] mv_a [NSLOT];
  logic             unused_wdata;

  assign word    = host_addr[ADDR_W-1:2];
  assign aligned = (host_addr[1:0] == 2'b00);
  assign wr_ok   = host_wr & aligned;
  assign unused_wdata = ^host_wdata[DATA_W-1:17];

  // control, software reset and interrupt control words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= 3'b001;
      swrst   <= 1'b0;
      intc_lo <= '0;
      intc_en <= '0;
    end else if (wr_ok) begin
      if (word == WRD_W'(W_CTRL))  ctrl    <= host_wdata[2:0];
      if (word == WRD_W'(W_SWRST)) swrst   <= host_wdata[0];
      if (word == WRD_W'(W_INTC)) begin
        intc_lo <= host_wdata[1:0];
        intc_en <= host_wdata[8 +: NEV];
      end
    end
  end

  // frame boundary: end of vertical blanking gated by enable and semaphore
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vb_q <= 1'b0;
    else        vb_q <= vblank_in;
  end
  assign commit = vb_q & ~vblank_in & ctrl[0] & ctrl[1];

  // tracking stops at the first timing write, resumes on any reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         frozen <= 1'b0;
    else if (swrst)     frozen <= 1'b0;
    else if (|slot_wr)  frozen <= 1'b1;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_wr[g] = wr_ok && (word == WRD_W'(W_SLOT0 + g));
    tmr_shadow_slot #(.SW(SLOT_W), .KEEP(slot_w(g, COLS_W, ROWS_W))) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .swrst     (swrst),
      .track     (~frozen),
      .commit    (commit),
      .wr_hit    (slot_wr[g]),
      .wval      (host_wdata[SLOT_W-1:0]),
      .meas      (meas_flat[g*SLOT_W +: SLOT_W]),
      .meas_view (mv_a[g]),
      .shadow    (sh_a[g]),
      .work      (wk_a[g])
    );
    assign work_flat[g*SLOT_W +: SLOT_W] = swrst ? '0 : wk_a[g];
  end

  // mosaic phase, double-buffered but not tracked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_shadow <= '0;
      ph_work   <= '0;
    end else if (swrst) begin
      ph_shadow <= '0;
      ph_work   <= '0;
    end else begin
      if (wr_ok && word == WRD_W'(W_PHASE)) ph_shadow <= host_wdata[1:0];
      if (commit) ph_work <= ph_shadow;
    end
  end

  assign bayer_out = swrst ? 2'b00 : ph_work;
  assign core_en   = ctrl[0] & ~swrst;

  tmr_irq_agg #(.NEV(NEV)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_in),
    .clr_stat (ctrl[2]),
    .glob_en  (intc_lo[0]),
    .src_en   (intc_en),
    .clr_src  (intc_lo[1]),
    .stat     (stat),
    .irq      (irq)
  );

  always_comb begin
    host_rdata = '0;
    if (aligned) begin
      case (int'(word))
        W_CTRL:  host_rdata = DATA_W'(ctrl);
        W_SWRST: host_rdata = DATA_W'(swrst);
        W_STAT:  host_rdata = DATA_W'({stat, lock_in, 7'b0});
        W_INTC:  host_rdata = DATA_W'({intc_en, 6'b0, intc_lo});
        W_PHASE: host_rdata = DATA_W'(ph_shadow);
        default: host_rdata = '0;
      endcase
      for (int i = 0; i < NSLOT; i++) begin
        if (int'(word) == W_SLOT0 + i) host_rdata = DATA_W'(sh_a[i]);
        if (int'(word) == W_MEAS0 + i) host_rdata = DATA_W'(mv_a[i]);
      end
    end
  end

  p_freeze_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !swrst) |=> frozen);
  p_phase_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !swrst) |=> (ph_work == $past(ph_shadow)));
endmodule

// File: tb/tmr_regbank_tb_top.sv
module tmr_regbank_tb_top;
  localparam int SW = 10;
  localparam int NS = 10;

  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    host_addr = '0;
  logic          host_wr = 1'b0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   host_rdata;
  logic          vblank_in = 1'b0;
  logic          lock_in = 1'b0;
  logic [8:0]    evt_in = '0;
  logic [NS*SW-1:0] meas_flat = '0;
  logic [NS*SW-1:0] work_flat;
  logic [1:0]    bayer_out;
  logic          core_en;
  logic          irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t sb[$];
  event mon_ev;

  always #5 clk = ~clk;

  tmr_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .vblank_in(vblank_in),
    .lock_in(lock_in), .evt_in(evt_in), .meas_flat(meas_flat),
    .work_flat(work_flat), .bayer_out(bayer_out), .core_en(core_en), .irq(irq)
  );

  // monitor: pops expected items and compares against the selected output
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      @(mon_ev);
      it = sb.pop_front();
      if (it.sel < 100)       act = host_rdata;
      else if (it.sel < 200)  act = 32'(work_flat[(it.sel-100)*SW +: SW]);
      else if (it.sel == 200) act = 32'(irq);
      else if (it.sel == 201) act = 32'(core_en);
      else                    act = 32'(bayer_out);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.tag, it.sel, act, it.exp);
      end
    end
  end

  task automatic push(int sel, logic [31:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    #1 -> mon_ev;
    #1;
  endtask

  task automatic exp_rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    host_addr = a;
    host_wr = 1'b0;
    push(0, exp, tag);
  endtask

  task automatic exp_out(int sel, logic [31:0] exp, string tag);
    @(negedge clk);
    push(sel, exp, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic set_meas(int i, int v);
    meas_flat[i*SW +: SW] = SW'(v);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic vb_pulse();
    @(negedge clk); vblank_in = 1'b1;
    idle(2);
    vblank_in = 1'b0;
    idle(2);
  endtask

  task automatic pulse_evt(int b);
    @(negedge clk); evt_in[b] = 1'b1;
    @(negedge clk); evt_in[b] = 1'b0;
    idle(3);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) set_meas(i, 100 + i);
    set_meas(9, 2);
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    exp_rd(8'h00, 32'h1, "R1 ctrl");
    exp_rd(8'h04, 32'h0, "R1 swrst");
    exp_rd(8'h0C, 32'h0, "R1 intc");
    exp_rd(8'h08, 32'h0, "R1 status");
    exp_out(200, 32'h0, "R1 irq");

    // R3 tracking before any write
    for (int i = 0; i < 9; i++) exp_rd(8'(8'h10 + 4*i), 32'(100 + i), "R3 slot track");
    exp_rd(8'h34, 32'h2, "R3 polarity track");
    exp_out(100, 32'd100, "R3 work0");
    set_meas(0, 200);
    idle(2);
    exp_rd(8'h10, 32'd200, "R3 follows change");
    exp_out(100, 32'd200, "R3 work0 follows");

    // R6 measured readback, writes ignored
    exp_rd(8'h3C, 32'd200, "R6 meas0");
    exp_rd(8'h60, 32'h2, "R6 meas9");
    wr(8'h3C, 32'h5);
    exp_rd(8'h3C, 32'd200, "R6 write ignored");

    // R2 readback
    wr(8'h00, 32'h5);
    exp_rd(8'h00, 32'h5, "R2 ctrl");
    wr(8'h00, 32'h1);
    wr(8'h0C, 32'hFFFF_FFFF);
    exp_rd(8'h0C, 32'h0001_FF03, "R2 intc mask");
    wr(8'h04, 32'h0);
    exp_rd(8'h04, 32'h0, "R2 swrst");

    // R4 / R10 freeze and truncation
    wr(8'h10, 32'hFFFF_F3FF);
    wr(8'h18, 32'h0000_07FF);
    exp_rd(8'h10, 32'h3FF, "R10 column truncation");
    exp_rd(8'h18, 32'h1FF, "R10 row truncation");
    set_meas(1, 300);
    idle(2);
    exp_rd(8'h14, 32'd101, "R4 unwritten slot frozen");
    exp_out(101, 32'd101, "R4 work1 frozen");
    exp_out(100, 32'd200, "R4 work0 awaits commit");

    // R11 / R5 commit gating
    wr(8'h38, 32'h2);
    exp_rd(8'h38, 32'h2, "R11 phase readback");
    vb_pulse();
    exp_out(100, 32'd200, "R5 no commit without semaphore");
    exp_out(202, 32'h0, "R11 phase not committed");
    wr(8'h00, 32'h3);
    vb_pulse();
    exp_out(100, 32'h3FF, "R5 commit slot0");
    exp_out(102, 32'h1FF, "R5 commit slot2");
    exp_out(101, 32'd101, "R5 commit slot1");
    exp_out(202, 32'h2, "R11 phase committed");

    // R8 / R9 status and interrupt
    wr(8'h0C, 32'h0000_0101);
    lock_in = 1'b1;
    exp_rd(8'h08, 32'h80, "R8 lock bit");
    lock_in = 1'b0;
    pulse_evt(1);
    exp_rd(8'h08, 32'h200, "R8 sticky bit9");
    exp_out(200, 32'h0, "R9 disabled source");
    pulse_evt(0);
    exp_rd(8'h08, 32'h300, "R8 sticky bit8");
    exp_out(200, 32'h1, "R9 enabled source");
    wr(8'h00, 32'h7);
    exp_rd(8'h08, 32'h0, "R8 status cleared");
    exp_out(200, 32'h1, "R9 irq held after status clear");
    wr(8'h00, 32'h3);
    wr(8'h0C, 32'h0000_0103);
    wr(8'h0C, 32'h0000_0101);
    exp_out(200, 32'h0, "R9 source cleared");

    // R7 software reset
    wr(8'h04, 32'h1);
    exp_rd(8'h04, 32'h1, "R7 swrst readback");
    exp_out(201, 32'h0, "R7 core_en zero");
    exp_out(100, 32'h0, "R7 work zero");
    exp_out(202, 32'h0, "R7 phase zero");
    wr(8'h04, 32'h0);
    set_meas(1, 333);
    idle(2);
    exp_rd(8'h14, 32'd333, "R7 tracking resumed");
    exp_out(101, 32'd333, "R7 work tracks again");
    exp_out(201, 32'h1, "R7 core_en back");

    idle(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule